// File: doc/BRIEF.md
# Cipher Key and IV Sequencer

This block is the control sequencer that sits beside a block-cipher storage engine. It watches a 4-bit switch input. When the switch value changes, it loads a new 256-bit cipher key and a new 256-bit tweak key, each picked from a fixed set of four constants. It then runs the engine's key-expansion handshake: a one-cycle key-valid pulse out, and a one-cycle key-finish pulse back from the engine. A key reload waits until the host is idle, so the key never changes in the middle of a transfer.

Each host command is marked by a rising edge of the host busy flag. On that edge the block captures the command's 48-bit start address as a 128-bit initialisation vector, with zeros added on the left. It then issues a one-cycle init-start pulse to the engine. If key expansion is still running, the block holds the captured command until the key is ready, so no command is dropped while the key is changing. After reset the block forces one key reload, so a valid key is in place before the first command.

Top module: `cipher_key_iv_seq`

## Requirements
- R1: A key reload begins only while host_busy is low and the synchronised switch value differs from the value used by the last accepted reload. With the host idle and the key ready, key_valid rises on the third clock after sw_in changes: two synchroniser stages, then the acceptance register.
- R2: When a reload begins, key_ready goes low and key_valid is high for exactly one cycle, in the cycle after acceptance.
- R3: key_ready stays low until the engine pulses key_finish, and goes high in the cycle after that pulse.
- R4: sw_in[1:0] selects cipher_key, which is loaded when the reload is accepted. The four constants are:
  - 00: the bytes 00,11,22,…,FF from the most significant byte down, repeated twice.
  - 01: the bitwise inverse of 00.
  - 10: the 16-bit groups 0000,1111,…,FFFF from the most significant group down.
  - 11: the bitwise inverse of 10.
- R5: sw_in[3:2] selects tweak_key from the same four constants, with the same encoding.
- R6: In the cycle after a rising edge of host_busy, iv_out holds host_addr zero-extended on the left to 128 bits.
- R7: init_start is a one-cycle pulse. It fires in the cycle after a captured command is pending while key_ready is high, and the pending command is cleared when it fires.
- R8: A command captured while key_ready is low produces no init_start until key_ready rises. init_start then fires in the cycle after key_ready rises.
- R9: One period of host_busy held high produces exactly one init_start.
- R10: During reset, key_valid, key_ready and init_start are low. After reset is released, a reload is forced at once if the host is idle, loading the keys chosen by the synchronised switch value, which reads as 0 after reset.
- R11: A reload does not begin while a captured command is waiting for its init_start. The reload is deferred to the cycle after that start fires.
- R12: A switch change that returns to the last loaded value before the host becomes idle causes no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_in | input | 4 | Switch value, asynchronous; [1:0] selects the cipher key, [3:2] selects the tweak key |
| host_busy | input | 1 | Host busy flag; a rising edge marks a new command |
| host_addr | input | 48 | Command start address |
| key_finish | input | 1 | One-cycle pulse from the engine when key expansion completes |
| key_valid | output | 1 | One-cycle request to the engine to expand new keys |
| key_ready | output | 1 | Keys are expanded and usable |
| cipher_key | output | 256 | Selected cipher key |
| tweak_key | output | 256 | Selected tweak key |
| iv_out | output | 128 | Captured initialisation vector |
| init_start | output | 1 | One-cycle command start to the engine |

## Verification
The hardest case to reach is a command left pending while key_ready is low, with host_busy already back low and a switch change waiting. In that state only the pending command stops the new reload. The stimulus starts a reload and withholds key_finish. It raises and then drops host_busy to capture a command, and changes the switches. It then releases key_finish and checks that init_start comes one cycle before key_valid. A second hard case is a switch change that is reverted while the host is busy, which must leave no reload behind.

// File: rtl/ckis_pkg.sv
package ckis_pkg;

  localparam int KEY_W = 256;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    KS_FORCE = 2'd0,
    KS_READY = 2'd1,
    KS_PULSE = 2'd2,
    KS_WAIT  = 2'd3
  } ks_state_e;

  // Selector bit 0 inverts the base pattern; selector bit 1 picks
  // the byte-ramp (0) or the 16-bit-group ramp (1) base pattern.
  function automatic logic [KEY_W-1:0] key_const(input logic [SEL_W-1:0] sel);
    logic [KEY_W-1:0] v;
    v = '0;
    if (sel[1] == 1'b0) begin
      for (int b = 0; b < KEY_W/8; b++) begin
        v[KEY_W-1-8*b -: 8] = 8'((b % 16) * 17);
      end
    end else begin
      for (int h = 0; h < KEY_W/16; h++) begin
        v[KEY_W-1-16*h -: 16] = 16'((h % 16) * 16'h1111);
      end
    end
    if (sel[0]) v = ~v;
    return v;
  endfunction

endpackage

// File: rtl/ckis_sw_track.sv
module ckis_sw_track #(
  parameter int SW_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] sw_in,
  input  logic            accept,
  output logic [SW_W-1:0] sw_sync,
  output logic            sw_changed
);

  logic [SW_W-1:0] ref_q;
  logic [SW_W-1:0] ref_d;

  generate
    if (SYNC_STAGES < 2) begin : g_one
      logic [SW_W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= sw_in;
      end
      assign sw_sync = stg_q;
    end else begin : g_multi
      logic [SYNC_STAGES-1:0][SW_W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[SYNC_STAGES-2:0], sw_in};
      end
      assign sw_sync = stg_q[SYNC_STAGES-1];
    end
  endgenerate

  // Reference copy moves only when a reload is accepted
  always_comb begin
    ref_d = ref_q;
    if (accept) ref_d = sw_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  assign sw_changed = (sw_sync != ref_q);

endmodule

// File: rtl/ckis_key_ctrl.sv
module ckis_key_ctrl
  import ckis_pkg::*;
#(
  parameter int SW_W = 2*SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW_W-1:0]  sw_sync,
  input  logic             sw_changed,
  input  logic             host_busy,
  input  logic             cmd_pending,
  input  logic             key_finish,
  output logic             accept,
  output logic             key_valid,
  output logic             key_ready,
  output logic [KEY_W-1:0] cipher_key,
  output logic [KEY_W-1:0] tweak_key
);

  ks_state_e        state_q, state_d;
  logic [KEY_W-1:0] ckey_q, tkey_q;
  logic [KEY_W-1:0] ckey_d, tkey_d;
  logic             may_start;

  always_comb begin
    may_start = !host_busy && !cmd_pending;
    accept    = 1'b0;
    state_d   = state_q;
    case (state_q)
      KS_FORCE: if (may_start) begin
        accept  = 1'b1;
        state_d = KS_PULSE;
      end
      KS_READY: if (sw_changed && may_start) begin
        accept  = 1'b1;
        state_d = KS_PULSE;
      end
      KS_PULSE: state_d = KS_WAIT;
      KS_WAIT:  if (key_finish) state_d = KS_READY;
      default:  state_d = KS_FORCE;
    endcase
  end

  always_comb begin
    ckey_d = ckey_q;
    tkey_d = tkey_q;
    if (accept) begin
      ckey_d = key_const(sw_sync[SEL_W-1:0]);
      tkey_d = key_const(sw_sync[2*SEL_W-1:SEL_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_FORCE;
      ckey_q  <= '0;
      tkey_q  <= '0;
    end else begin
      state_q <= state_d;
      ckey_q  <= ckey_d;
      tkey_q  <= tkey_d;
    end
  end

  assign key_valid  = (state_q == KS_PULSE);
  assign key_ready  = (state_q == KS_READY);
  assign cipher_key = ckey_q;
  assign tweak_key  = tkey_q;

endmodule

// File: rtl/ckis_iv_ctrl.sv
module ckis_iv_ctrl #(
  parameter int ADDR_W = 48,
  parameter int IV_W   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_busy,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              key_ready,
  output logic [IV_W-1:0]   iv_out,
  output logic              init_start,
  output logic              cmd_pending
);

  localparam int PAD_W = IV_W - ADDR_W;

  logic            busy_q;
  logic            pend_q, pend_d;
  logic            start_q, start_d;
  logic [IV_W-1:0] iv_q, iv_d;
  logic            busy_rise;
  logic            fire;

  always_comb begin
    busy_rise = host_busy && !busy_q;
    fire      = pend_q && key_ready;
    start_d   = fire;
    pend_d    = pend_q;
    iv_d      = iv_q;
    if (fire)      pend_d = 1'b0;
    if (busy_rise) begin
      pend_d = 1'b1;
      iv_d   = {{PAD_W{1'b0}}, host_addr};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      iv_q    <= '0;
    end else begin
      busy_q  <= host_busy;
      pend_q  <= pend_d;
      start_q <= start_d;
      iv_q    <= iv_d;
    end
  end

  assign iv_out      = iv_q;
  assign init_start  = start_q;
  assign cmd_pending = pend_q;

endmodule

// File: rtl/cipher_key_iv_seq.sv
module cipher_key_iv_seq
  import ckis_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int IV_W        = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        sw_in,
  input  logic              host_busy,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              key_finish,
  output logic              key_valid,
  output logic              key_ready,
  output logic [KEY_W-1:0]  cipher_key,
  output logic [KEY_W-1:0]  tweak_key,
  output logic [IV_W-1:0]   iv_out,
  output logic              init_start
);

  localparam int SW_W = 2*SEL_W;

  logic [SW_W-1:0] sw_sync;
  logic            sw_changed;
  logic            accept;
  logic            cmd_pending;

  ckis_sw_track #(
    .SW_W        (SW_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) sw_track_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_in      (sw_in),
    .accept     (accept),
    .sw_sync    (sw_sync),
    .sw_changed (sw_changed)
  );

  ckis_key_ctrl #(
    .SW_W (SW_W)
  ) key_ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_sync     (sw_sync),
    .sw_changed  (sw_changed),
    .host_busy   (host_busy),
    .cmd_pending (cmd_pending),
    .key_finish  (key_finish),
    .accept      (accept),
    .key_valid   (key_valid),
    .key_ready   (key_ready),
    .cipher_key  (cipher_key),
    .tweak_key   (tweak_key)
  );

  ckis_iv_ctrl #(
    .ADDR_W (ADDR_W),
    .IV_W   (IV_W)
  ) iv_ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_busy   (host_busy),
    .host_addr   (host_addr),
    .key_ready   (key_ready),
    .iv_out      (iv_out),
    .init_start  (init_start),
    .cmd_pending (cmd_pending)
  );

endmodule

// File: rtl/ckis_seq_chk.sv
module ckis_seq_chk #(
  parameter int ADDR_W = 48,
  parameter int IV_W   = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_busy,
  input logic [ADDR_W-1:0] host_addr,
  input logic              key_finish,
  input logic              key_valid,
  input logic              key_ready,
  input logic [IV_W-1:0]   iv_out,
  input logic              init_start,
  input logic              cmd_pending
);

  AST_RELOAD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_ready) |-> !$past(host_busy)); // R1

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid); // R2

  AST_VALID_WITH_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_ready) |-> key_valid); // R2

  AST_READY_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_ready) |-> $past(key_finish)); // R3

  AST_IV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_busy) |=> (iv_out == {{(IV_W-ADDR_W){1'b0}}, $past(host_addr)})); // R6

  AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |-> $past(key_ready)); // R8

  AST_NO_RELOAD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> !$past(cmd_pending)); // R11

endmodule

bind cipher_key_iv_seq ckis_seq_chk #(
  .ADDR_W (ADDR_W),
  .IV_W   (IV_W)
) seq_chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_busy   (host_busy),
  .host_addr   (host_addr),
  .key_finish  (key_finish),
  .key_valid   (key_valid),
  .key_ready   (key_ready),
  .iv_out      (iv_out),
  .init_start  (init_start),
  .cmd_pending (cmd_pending)
);

// File: tb/cipher_key_iv_seq_tb_top.sv
`timescale 1ns/1ps
module cipher_key_iv_seq_tb_top;

  localparam logic [255:0] K0 = {2{128'h00112233445566778899AABBCCDDEEFF}};
  localparam logic [255:0] K1 = ~K0;
  localparam logic [255:0] K2 =
    256'h0000111122223333444455556666777788889999AAAABBBBCCCCDDDDEEEEFFFF;
  localparam logic [255:0] K3 = ~K2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   sw_in;
  logic         host_busy;
  logic [47:0]  host_addr;
  logic         key_finish;
  logic         key_valid;
  logic         key_ready;
  logic [255:0] cipher_key;
  logic [255:0] tweak_key;
  logic [127:0] iv_out;
  logic         init_start;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cipher_key_iv_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_in      (sw_in),
    .host_busy  (host_busy),
    .host_addr  (host_addr),
    .key_finish (key_finish),
    .key_valid  (key_valid),
    .key_ready  (key_ready),
    .cipher_key (cipher_key),
    .tweak_key  (tweak_key),
    .iv_out     (iv_out),
    .init_start (init_start)
  );

  function automatic logic [255:0] exp_key(input logic [1:0] s);
    case (s)
      2'b00:   return K0;
      2'b01:   return K1;
      2'b10:   return K2;
      default: return K3;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic [255:0] act, input logic [255:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_valid(input int lim, output int n);
    n = 0;
    while (key_valid !== 1'b1 && n < lim) begin
      tick();
      n++;
    end
  endtask

  task automatic finish_keys();
    chk(key_ready, 0, "R3 ready low before finish");
    key_finish = 1'b1;
    tick();
    key_finish = 1'b0;
    chk(key_ready, 1, "R3 ready after finish");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sw_in = 4'h0; host_busy = 1'b0; host_addr = '0; key_finish = 1'b0;
    tick(); tick();
    chk({key_valid, key_ready, init_start}, 0, "R10 outputs in reset");
    rst_n = 1'b1;
    tick();
    chk(key_valid, 1, "R10 forced reload after reset");
    chk(key_ready, 0, "R2 ready low on reload");
    chk(cipher_key, K0, "R10 cipher key after reset");
    chk(tweak_key, K0, "R10 tweak key after reset");
    tick();
    chk(key_valid, 0, "R2 valid single cycle");
    tick();
    finish_keys();
  endtask

  task automatic t_switch(input logic [3:0] v);
    int n;
    sw_in = v;
    wait_valid(10, n);
    chk(n, 3, "R1 reload latency");
    chk(key_ready, 0, "R2 ready low");
    chk(cipher_key, exp_key(v[1:0]), "R4 cipher key select");
    chk(tweak_key, exp_key(v[3:2]), "R5 tweak key select");
    tick();
    chk(key_valid, 0, "R2 valid single cycle");
    finish_keys();
  endtask

  task automatic t_defer();
    logic saw_valid;
    host_addr = 48'hA5A5_1234_0123;
    host_busy = 1'b1;
    tick();
    chk(iv_out, {80'h0, 48'hA5A5_1234_0123}, "R6 iv capture");
    chk(init_start, 0, "R7 start not yet");
    tick();
    chk(init_start, 1, "R7 start pulse");
    tick();
    chk(init_start, 0, "R7 start one cycle");
    sw_in = 4'b0100;
    saw_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (key_valid) saw_valid = 1'b1;
    end
    chk(saw_valid, 0, "R1 no reload while busy");
    chk(key_ready, 1, "R1 ready kept while busy");
    host_busy = 1'b0;
    tick();
    chk(key_valid, 1, "R1 reload once idle");
    chk(cipher_key, K0, "R4 cipher key sel 00");
    chk(tweak_key, K1, "R5 tweak key sel 01");
    tick();
    finish_keys();
  endtask

  task automatic t_hold();
    int n;
    logic saw;
    sw_in = 4'b1011;
    wait_valid(10, n);
    chk(cipher_key, K3, "R4 cipher key sel 11");
    chk(tweak_key, K2, "R5 tweak key sel 10");
    tick();
    host_addr = 48'h0000_0000_0124;
    host_busy = 1'b1;
    tick();
    chk(iv_out, {80'h0, 48'h0000_0000_0124}, "R6 iv capture while loading");
    saw = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (init_start) saw = 1'b1;
      tick();
    end
    chk(saw, 0, "R8 start held while not ready");
    finish_keys();
    chk(init_start, 0, "R8 start not with ready rise");
    tick();
    chk(init_start, 1, "R8 start after ready");
    tick();
    chk(init_start, 0, "R7 start one cycle");
    host_busy = 1'b0;
    tick();
  endtask

  task automatic t_once();
    int cnt;
    cnt = 0;
    host_addr = 48'h1111_2222_3333;
    host_busy = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (init_start) cnt++;
    end
    chk(cnt, 1, "R9 one start per busy period");
    host_busy = 1'b0;
    tick(); tick();
  endtask

  task automatic t_pending_block();
    int n;
    sw_in = 4'b0000;
    wait_valid(10, n);
    tick();
    host_addr = 48'h0000_CAFE_0001;
    host_busy = 1'b1;
    tick(); tick();
    host_busy = 1'b0;
    sw_in = 4'b0101;
    for (int i = 0; i < 5; i++) tick();
    finish_keys();
    chk(key_valid, 0, "R11 no reload on ready rise");
    tick();
    chk(init_start, 1, "R11 pending start goes first");
    chk(key_valid, 0, "R11 reload deferred behind start");
    tick();
    chk(key_valid, 1, "R11 reload after start");
    chk(cipher_key, K1, "R4 cipher key sel 01");
    chk(tweak_key, K1, "R5 tweak key sel 01");
    tick();
    finish_keys();
  endtask

  task automatic t_revert();
    logic saw;
    host_addr = 48'h0000_0000_0777;
    host_busy = 1'b1;
    sw_in = 4'b1111;
    for (int i = 0; i < 4; i++) tick();
    sw_in = 4'b0101;
    for (int i = 0; i < 4; i++) tick();
    host_busy = 1'b0;
    saw = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (key_valid) saw = 1'b1;
    end
    chk(saw, 0, "R12 reverted change gives no reload");
    chk(key_ready, 1, "R12 ready kept");
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_switch(4'b0001);
    t_switch(4'b1110);
    t_defer();
    t_hold();
    t_once();
    t_pending_block();
    t_revert();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule